// File: doc/BRIEF.md
# String Descriptor Table Walker

This block answers a request for one string descriptor out of a table kept in a 256-byte configuration memory. The table begins at a fixed byte offset. Each entry is a single length byte, then a type byte, then the string payload. No index table exists, so entry k can only be found by starting at the first entry and skipping forward by each length byte in turn. When the requested entry is reached, its bytes go out on a byte stream toward the control-IN data path. A `done` pulse marks the end of the reply.

There are three ways a request can produce a zero-length reply. The index may be larger than the highest user index. The walk may meet a zero-length terminator first. An entry may claim a length that would carry the next-entry address past the last memory byte. A reply is never longer than the host's requested length. The memory port has a read enable and returns data one clock after the address.

Top module: `strdesc_walker`

## Requirements
- R1: After an accepted start with an in-range index, the first memory read is at byte address 16. Entry k+1 is looked for at the address of entry k plus entry k's length byte.
- R2: A selected entry is sent starting with its length byte, then the following bytes in ascending address order, one byte per clock with `out_valid` high. The number of bytes sent is the smaller of the length byte and `req_len`.
- R3: If a length byte of 0 is read before the requested index is reached, the reply has zero length.
- R4: An index above 6 produces a zero-length reply and issues no memory read.
- R5: An entry at address p with length byte L where p+L > 255 is treated as the table terminator. The reply is zero length for that index and for every later one. An entry with p+L = 255 is still valid.
- R6: `out_last` is high together with the final byte of a reply and at no other time. `done` is high in that same cycle.
- R7: A zero-length reply, which includes any request with `req_len` = 0, raises `done` for exactly one cycle and never raises `out_valid`. After reset, `out_valid`, `out_last`, `done` and `mem_rd_en` are all low.
- R8: A `start` pulse that arrives while a request is in progress is ignored. The reply belongs to the first request, and no second reply follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe; accepted only when idle |
| str_index | input | 8 | Requested string index |
| req_len | input | 16 | Host-requested byte count |
| mem_rd_en | output | 1 | Memory read enable |
| mem_addr | output | 8 | Memory byte address |
| mem_rdata | input | 8 | Read data, valid one cycle after the read |
| out_valid | output | 1 | A reply byte is on `out_data` |
| out_data | output | 8 | Reply byte |
| out_last | output | 1 | Final byte of the reply |
| done | output | 1 | Reply complete, with or without data |

## Verification
The hardest case to reach is the guard against a corrupt chain. It only triggers when an entry's length lands its successor exactly on byte 256 or beyond, and it must be told apart from an entry that ends flush at byte 255. The bench builds dedicated tables for both cases: one whose second entry runs from byte 56 with length 200, and one whose second entry ends on byte 254. It sweeps every index from 0 to 8 against several requested lengths on each table. It also sends a second `start` in the middle of a walk.

// File: rtl/strwalk_pkg.sv
package strwalk_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_HOP_RD,
        WK_HOP_EVAL,
        WK_SEND
    } walk_state_t;

    // Bytes to stream: the entry length, cut down to the host's request.
    function automatic byte_t clip_len(byte_t entry_len, int unsigned want);
        return (want < 32'(entry_len)) ? byte_t'(want) : entry_len;
    endfunction

endpackage

// File: rtl/strw_hop.sv
module strw_hop
    import strwalk_pkg::*;
#(
    parameter int AW         = 8,
    parameter int TABLE_BASE = 16,
    parameter int CUR_W      = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             adv,
    input  byte_t            blen,
    output logic [AW-1:0]    ptr,
    output logic [CUR_W-1:0] cur,
    output logic             next_ovf
);
    localparam int SUM_W = AW + 1;

    logic [SUM_W-1:0] sum;

    assign sum      = {1'b0, ptr} + SUM_W'(blen);
    assign next_ovf = sum[AW];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            cur <= '0;
        end else if (init) begin
            ptr <= AW'(TABLE_BASE);
            cur <= '0;
        end else if (adv) begin
            ptr <= sum[AW-1:0];
            cur <= cur + 1'b1;
        end
    end

    AST_HOP_INIT_BASE: assert property (@(posedge clk) disable iff (rst)
        init |=> (ptr == AW'(TABLE_BASE)) && (cur == '0)); // R1
    AST_HOP_FORWARD: assert property (@(posedge clk) disable iff (rst)
        (adv && !init && blen != 8'd0) |=> (ptr > $past(ptr))); // R5

endmodule

// File: rtl/strw_beat.sv
module strw_beat
    import strwalk_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  byte_t         count,
    output logic          busy,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          beat_valid,
    output logic          beat_last
);
    logic [AW-1:0] base_q;
    byte_t         off_q;
    byte_t         remain_q;

    assign busy    = (remain_q != 8'd0);
    assign rd_en   = busy;
    assign rd_addr = base_q + AW'(off_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q     <= '0;
            off_q      <= '0;
            remain_q   <= '0;
            beat_valid <= 1'b0;
            beat_last  <= 1'b0;
        end else begin
            beat_valid <= busy;
            beat_last  <= busy && (remain_q == 8'd1);
            if (load) begin
                base_q   <= base;
                off_q    <= '0;
                remain_q <= count;
            end else if (busy) begin
                off_q    <= off_q + 8'd1;
                remain_q <= remain_q - 8'd1;
            end
        end
    end

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !load && remain_q > 8'd1) |=> (rd_addr == $past(rd_addr) + 1'b1)); // R2
    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
        beat_last |-> beat_valid); // R6

endmodule

// File: rtl/strdesc_walker.sv
module strdesc_walker
    import strwalk_pkg::*;
#(
    parameter int AW         = 8,
    parameter int TABLE_BASE = 16,
    parameter int IDX_W      = 8,
    parameter int LEN_W      = 16,
    parameter int MAX_INDEX  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] str_index,
    input  logic [LEN_W-1:0] req_len,
    output logic             mem_rd_en,
    output logic [AW-1:0]    mem_addr,
    input  logic [7:0]       mem_rdata,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             done
);
    localparam int CUR_W = (MAX_INDEX < 1) ? 1 : $clog2(MAX_INDEX + 1);

    walk_state_t      st_q, st_d;
    logic [IDX_W-1:0] idx_q;
    logic [LEN_W-1:0] len_q;
    logic             zl_q, zl_set;

    logic             hop_init, hop_adv, hop_ovf;
    logic [AW-1:0]    hop_ptr;
    logic [CUR_W-1:0] hop_cur;

    logic             beat_load, beat_busy, beat_rd, beat_valid, beat_last;
    logic [AW-1:0]    beat_addr;
    byte_t            send_cnt;
    logic             accept, idx_ok, is_end, hit;

    strw_hop #(.AW(AW), .TABLE_BASE(TABLE_BASE), .CUR_W(CUR_W)) u_hop (
        .clk      (clk),
        .rst      (rst),
        .init     (hop_init),
        .adv      (hop_adv),
        .blen     (mem_rdata),
        .ptr      (hop_ptr),
        .cur      (hop_cur),
        .next_ovf (hop_ovf)
    );

    strw_beat #(.AW(AW)) u_beat (
        .clk        (clk),
        .rst        (rst),
        .load       (beat_load),
        .base       (hop_ptr),
        .count      (send_cnt),
        .busy       (beat_busy),
        .rd_en      (beat_rd),
        .rd_addr    (beat_addr),
        .beat_valid (beat_valid),
        .beat_last  (beat_last)
    );

    assign accept   = (st_q == WK_IDLE) && start;
    assign idx_ok   = (32'(str_index) <= 32'(MAX_INDEX));
    assign is_end   = (mem_rdata == 8'd0) || hop_ovf;
    assign hit      = (IDX_W'(hop_cur) == idx_q);
    assign send_cnt = clip_len(mem_rdata, 32'(len_q));

    always_comb begin
        st_d      = st_q;
        hop_init  = 1'b0;
        hop_adv   = 1'b0;
        beat_load = 1'b0;
        zl_set    = 1'b0;
        unique case (st_q)
            WK_IDLE: begin
                if (accept) begin
                    if (idx_ok) begin
                        hop_init = 1'b1;
                        st_d     = WK_HOP_RD;
                    end else begin
                        zl_set = 1'b1;
                    end
                end
            end
            WK_HOP_RD:  st_d = WK_HOP_EVAL;
            WK_HOP_EVAL: begin
                if (is_end) begin
                    zl_set = 1'b1;
                    st_d   = WK_IDLE;
                end else if (hit) begin
                    if (send_cnt == 8'd0) begin
                        zl_set = 1'b1;
                        st_d   = WK_IDLE;
                    end else begin
                        beat_load = 1'b1;
                        st_d      = WK_SEND;
                    end
                end else begin
                    hop_adv = 1'b1;
                    st_d    = WK_HOP_RD;
                end
            end
            WK_SEND: if (!beat_busy) st_d = WK_IDLE;
            default: st_d = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= WK_IDLE;
            idx_q <= '0;
            len_q <= '0;
            zl_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            zl_q <= zl_set;
            if (accept) begin
                idx_q <= str_index;
                len_q <= req_len;
            end
        end
    end

    assign mem_rd_en = beat_rd || (st_q == WK_HOP_RD);
    assign mem_addr  = beat_busy ? beat_addr : hop_ptr;
    assign out_valid = beat_valid;
    assign out_data  = beat_valid ? mem_rdata : 8'd0;
    assign out_last  = beat_last;
    assign done      = zl_q || beat_last;

    AST_ZL_NO_BEAT: assert property (@(posedge clk) disable iff (rst)
        zl_q |-> !out_valid); // R7
    AST_BAD_INDEX_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (accept && !idx_ok) |=> (!mem_rd_en && done)); // R4
    AST_FIRST_READ_BASE: assert property (@(posedge clk) disable iff (rst)
        (accept && idx_ok) |=> (mem_rd_en && mem_addr == AW'(TABLE_BASE))); // R1
    AST_BUSY_HOLDS_INDEX: assert property (@(posedge clk) disable iff (rst)
        (st_q != WK_IDLE) |=> $stable(idx_q)); // R8

endmodule

// File: tb/tb_strdesc_walker.sv
module tb_strdesc_walker;
    logic        clk = 1'b0;
    logic        rst, start;
    logic [7:0]  str_index;
    logic [15:0] req_len;
    logic        mem_rd_en, out_valid, out_last, done;
    logic [7:0]  mem_addr, mem_rdata, out_data;

    logic [7:0]  mem [256];
    int          n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    strdesc_walker dut (
        .clk(clk), .rst(rst), .start(start), .str_index(str_index),
        .req_len(req_len), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .done(done)
    );

    always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic build(input int kind);
        int lens[8];
        int n, p;
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + kind * 11) & 255);
        case (kind)
            0: begin lens = '{4, 10, 6, 2, 5, 3, 8, 0}; n = 8; end
            1: begin lens = '{4, 12, 0, 0, 0, 0, 0, 0}; n = 3; end
            2: begin lens = '{40, 200, 30, 0, 0, 0, 0, 0}; n = 4; end
            3: begin lens = '{0, 0, 0, 0, 0, 0, 0, 0}; n = 1; end
            4: begin lens = '{30, 30, 30, 30, 30, 30, 30, 0}; n = 8; end
            default: begin lens = '{4, 235, 0, 0, 0, 0, 0, 0}; n = 3; end
        endcase
        p = 16;
        for (int k = 0; k < n; k++) begin
            if (p > 255) break;
            mem[p] = 8'(lens[k]);
            if (lens[k] >= 2 && p + 1 <= 255) mem[p + 1] = 8'h03;
            if (lens[k] == 0) break;
            p += lens[k];
        end
    endtask

    // reason: 0 served, 1 terminator (R3), 2 overflow (R5), 3 bad index (R4), 4 zero request (R7)
    task automatic ref_walk(input int idx, input int want, output int p, output int cnt, output int why);
        int ptr, bl;
        p = 0; cnt = 0; why = 3;
        if (idx > 6) return;
        ptr = 16;
        for (int k = 0; k <= 6; k++) begin
            bl = int'(mem[ptr]);
            if (bl == 0) begin why = 1; return; end
            if (ptr + bl > 255) begin why = 2; return; end
            if (k == idx) begin
                p = ptr;
                cnt = (want < bl) ? want : bl;
                why = (cnt == 0) ? 4 : 0;
                return;
            end
            ptr += bl;
        end
    endtask

    task automatic run_req(input int idx, input int want, input bit poke, input int poke_idx);
        int p, cnt, why, got, cyc, nreads, first_addr;
        bit seen;
        string tag;
        ref_walk(idx, want, p, cnt, why);
        case (why)
            0: tag = "R2"; 1: tag = "R3"; 2: tag = "R5"; 3: tag = "R4"; default: tag = "R7";
        endcase
        @(negedge clk);
        start = 1'b1; str_index = 8'(idx); req_len = 16'(want);
        @(negedge clk);
        start = 1'b0;
        got = 0; cyc = 0; nreads = 0; first_addr = -1; seen = 1'b0;
        while (!seen && cyc < 3000) begin
            if (poke && cyc == 2) begin start = 1'b1; str_index = 8'(poke_idx); end
            else start = 1'b0;
            if (mem_rd_en) begin
                nreads++;
                if (first_addr < 0) first_addr = int'(mem_addr);
            end
            if (out_valid) begin
                check(got < cnt && out_data == mem[(p + got) & 255], poke ? "R8" : "R2",
                      int'(out_data), int'(mem[(p + got) & 255]));
                check(out_last == (got == cnt - 1), "R6", int'(out_last), int'(got == cnt - 1));
                got++;
            end
            if (done) begin
                seen = 1'b1;
                if (cnt > 0) check(out_valid && out_last, "R6", int'(out_last), 1);
                else check(!out_valid, "R7", int'(out_valid), 0);
            end
            if (!seen) begin @(negedge clk); cyc++; end
        end
        start = 1'b0;
        check(seen, "WATCHDOG", cyc, 0);
        check(got == cnt, poke ? "R8" : tag, got, cnt);
        if (idx > 6) check(nreads == 0, "R4", nreads, 0);
        else check(first_addr == 16, "R1", first_addr, 16);
        for (int q = 0; q < 4; q++) begin
            @(negedge clk);
            check(!out_valid && !done, poke ? "R8" : "R6", int'(out_valid | done), 0);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL WATCHDOG run did not finish actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int wants[4];
        wants = '{0, 1, 3, 300};
        rst = 1'b1; start = 1'b0; str_index = '0; req_len = '0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check(!out_valid && !out_last && !done && !mem_rd_en, "R7", 
              int'({out_valid, out_last, done, mem_rd_en}), 0);
        rst = 1'b0;
        for (int kind = 0; kind < 6; kind++) begin
            build(kind);
            for (int idx = 0; idx <= 8; idx++)
                for (int w = 0; w < 4; w++)
                    run_req(idx, wants[w], 1'b0, 0);
        end
        build(0);
        run_req(5, 300, 1'b1, 1);   // R8: second start mid-walk ignored
        build(4);
        run_req(6, 20, 1'b1, 0);    // R8
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule